// File: doc/BRIEF.md
# Multi-Port Video Skew Timestamp Unit

This block stamps two events on each of four camera input ports with the value of one shared free-running counter, so that software can compare the stamps and measure how far the video streams drift apart. The first stamp is taken when a frame begins, which is the rising edge of the port's vertical sync. The second is taken when the port starts receiving a chosen line of that frame. The block finds that line by counting per-line data-start strobes. It does not use horizontal sync or line-start packets.

Software freezes any set of ports before it reads their stamps. It then pulses one read strobe for each stamp it takes. When every stamp of every frozen port has been read, the freeze drops by itself. Software can also drop a freeze bit directly. Status outputs give a per-port valid flag, a ready flag, and a per-port flag that reports more than one frame start within one frame-sync period. The block runs either in free-run mode or locked to an external frame-sync pulse.

Top module: `vskew_stamp_unit`

## Requirements
- R1: All stamps come from one 32-bit counter. The counter reads 0 in the first cycle after reset is released, rises by one every clock and wraps from all ones to zero.
- R2: A frame start on a port is a cycle in which `vsync` is 1 and was 0 in the previous cycle. If that port is enabled and not frozen, `sof_stamp` takes the counter value of that cycle, and the new value is visible in the next cycle.
- R3: After a frame start, the port counts `line_begin` strobes starting from 1. A strobe in the frame-start cycle itself is not counted. The strobe whose count equals `line_sel` stores that cycle's counter value in `sol_stamp`, if the port is not frozen. No further line stamp is taken until the next frame start. When `line_sel` is 0, no line stamp is ever taken.
- R4: While its `port_en` bit is 0, a port takes no stamps and drives `stamp_valid` and `multi_sof` at 0 from the next cycle.
- R5: A 1 on a bit of `frz_set` sets that port's `frozen` bit. While that bit is set, the port's stamps and valid flag hold.
- R6: A frozen port records each `rd_sof` and `rd_sol` strobe it receives. The first cycle in which every frozen port has had both strobes is the release cycle, and all `frozen` bits are 0 in the next cycle. A 1 on a bit of `frz_clr` clears that bit. If `frz_set` is 1 for a port in the same cycle, it wins over release or clear.
- R7: `stamp_valid` of a port rises after a line stamp is captured. It clears after a new frame-start capture, after the port's frozen bit falls, and, in frame-sync mode, on a frame-sync pulse while the port is not frozen.
- R8: In free-run mode (`sync_mode`=0), `stamp_ready` is set in the cycle after every enabled port shows valid, provided at least one port is enabled. It then stays set.
- R9: In frame-sync mode (`sync_mode`=1), `stamp_ready` is set only in the cycle after a `fsync_pulse` that arrives while every enabled port shows valid.
- R10: `stamp_ready` is 0 in the cycle after any `frozen` bit falls. This takes priority over R8 and R9.
- R11: In frame-sync mode, `multi_sof` of an enabled port goes to 1 after the port's second frame start within one frame-sync period. A frame-sync pulse clears it and starts a new period. A frame start in the same cycle as the pulse counts as the first of the new period. In free-run mode the flag is 0.
- R12: After a cycle with `rst_n` low at a clock edge, all stamps, flags and `frozen` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| port_en | input | 4 | Per-port detection enable |
| sync_mode | input | 1 | 0 free-run, 1 frame-sync |
| fsync_pulse | input | 1 | One-cycle frame-sync pulse |
| line_sel | input | 12 | Line number that triggers the line stamp, shared by all ports |
| vsync | input | 4 | Per-port vertical sync, active high |
| line_begin | input | 4 | Per-port strobe at the start of each received line |
| frz_set | input | 4 | Per-port freeze request strobe |
| frz_clr | input | 4 | Per-port freeze clear strobe |
| rd_sof | input | 4 | Per-port strobe marking the frame stamp as read |
| rd_sol | input | 4 | Per-port strobe marking the line stamp as read |
| sof_stamp | output | 128 | Frame-start stamps, port p in bits [32p+31:32p] |
| sol_stamp | output | 128 | Line stamps, same packing |
| stamp_valid | output | 4 | Per-port valid flag |
| stamp_ready | output | 1 | Stamps ready |
| multi_sof | output | 4 | More than one frame start in a frame-sync period |
| frozen | output | 4 | Per-port freeze state |

## Verification
Each stamp, valid flag, multi-start flag and freeze bit is due one clock edge after the input cycle that causes it. The ready flag follows one edge after the valid flags it depends on, which is two edges after the strobe of the chosen line. The bench drives inputs on the falling edge. A behavioural model advances on the rising edge from those same inputs. Every output is compared with the model at the next falling edge, so each result is checked in exactly the cycle it is due. The stimulus uses unequal frame lengths on the four ports, so frame starts drift against each other and against the frame-sync pulse. This produces multiple starts in one period, frozen reads in a staggered order, a disabled port and a line number of zero.

// File: rtl/vskew_pkg.sv
// Package: shared types of the video skew timestamp unit.
// Assumes: nothing beyond IEEE 1800-2017.
package vskew_pkg;
    typedef enum logic {
        VSK_FREE_RUN   = 1'b0,
        VSK_FRAME_SYNC = 1'b1
    } vsk_mode_e;
endpackage

// File: rtl/vskew_counter.sv
// Module: free-running timestamp counter shared by all ports.
// Assumes: synchronous active-low reset; wraps silently at 2**W.
module vskew_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] now
);
    // Advance the timebase by one every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) now <= '0;
        else        now <= now + W'(1);
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> now == $past(now) + W'(1)); // R1
endmodule

// File: rtl/vskew_freeze.sv
// Module: per-port freeze bits with self-release once all frozen stamps are read.
// Assumes: strobes are one cycle wide; read strobes on unfrozen ports are ignored.
module vskew_freeze #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] frz_set,
    input  logic [N-1:0] frz_clr,
    input  logic [N-1:0] rd_sof,
    input  logic [N-1:0] rd_sol,
    output logic [N-1:0] frozen,
    output logic [N-1:0] frz_fall
);
    logic [N-1:0] got_sof, got_sol, frozen_n, port_done;
    logic         release_all;

    // Decide per port whether its two stamps have been read (including this cycle).
    always_comb begin
        port_done   = ~frozen | ((got_sof | rd_sof) & (got_sol | rd_sol));
        release_all = (|frozen) & (&port_done);
        frozen_n    = frz_set | (frozen & ~frz_clr & {N{~release_all}});
        frz_fall    = frozen & ~frozen_n;
    end

    // Register freeze state and the per-stamp read record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frozen  <= '0;
            got_sof <= '0;
            got_sol <= '0;
        end else begin
            frozen  <= frozen_n;
            got_sof <= ~frz_set & (got_sof | (rd_sof & frozen));
            got_sol <= ~frz_set & (got_sol | (rd_sol & frozen));
        end
    end

    AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(rd_sof | rd_sol) == '0)
        |-> (($past(frozen) & ~$past(frz_clr) & ~frozen) == '0)); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(frz_set) & ~frozen) == '0)); // R5
endmodule

// File: rtl/vskew_port.sv
// Module: one input port - frame-start and line stamp capture, valid and multi-start flags.
// Assumes: vsync active high; line_begin pulses once at the start of every received line.
module vskew_port #(
    parameter int TS_W   = 32,
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              frozen,
    input  logic              frz_fall,
    input  logic              fs_mode,
    input  logic              fsync,
    input  logic [LINE_W-1:0] line_sel,
    input  logic              vsync,
    input  logic              line_begin,
    input  logic [TS_W-1:0]   now,
    output logic [TS_W-1:0]   sof_ts,
    output logic [TS_W-1:0]   sol_ts,
    output logic              valid,
    output logic              multi_sof
);
    localparam int LW1 = LINE_W + 1;

    logic              vs_q, armed, sof_seen, sof_edge, line_hit;
    logic [LINE_W-1:0] lcnt;

    // Detect a frame start and the arrival of the selected line.
    always_comb begin
        sof_edge = en & vsync & ~vs_q;
        line_hit = en & armed & ~sof_edge & line_begin &
                   ((LW1'(lcnt) + LW1'(1)) == LW1'(line_sel));
    end

    // Track vsync history and count lines after each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q  <= 1'b0;
            armed <= 1'b0;
            lcnt  <= '0;
        end else begin
            vs_q <= vsync;
            if (!en) begin
                armed <= 1'b0;
                lcnt  <= '0;
            end else if (sof_edge) begin
                armed <= 1'b1;
                lcnt  <= '0;
            end else if (line_begin && armed) begin
                lcnt <= lcnt + LINE_W'(1);
                if (line_hit) armed <= 1'b0;
            end
        end
    end

    // Capture stamps and maintain the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sof_ts <= '0;
            sol_ts <= '0;
            valid  <= 1'b0;
        end else begin
            if (sof_edge && !frozen) sof_ts <= now;
            if (line_hit && !frozen) sol_ts <= now;
            if (!en || frz_fall)              valid <= 1'b0;
            else if (!frozen) begin
                if (line_hit)                 valid <= 1'b1;
                else if (sof_edge)            valid <= 1'b0;
                else if (fs_mode && fsync)    valid <= 1'b0;
            end
        end
    end

    // Flag a second frame start within one frame-sync period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || !fs_mode) begin
            sof_seen  <= 1'b0;
            multi_sof <= 1'b0;
        end else if (fsync) begin
            sof_seen  <= sof_edge;
            multi_sof <= 1'b0;
        end else if (sof_edge) begin
            sof_seen  <= 1'b1;
            multi_sof <= multi_sof | sof_seen;
        end
    end

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(frozen) |-> $stable(sof_ts) && $stable(sol_ts)); // R5
    AST_OFF_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(en) |-> !valid); // R4
    AST_MULTI_ONLY_FS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(en && fs_mode) |-> !multi_sof); // R11
endmodule

// File: rtl/vskew_stamp_unit.sv
// Module: top of the multi-port video skew timestamp unit.
// Assumes: all inputs synchronous to clk; strobes one cycle wide.
module vskew_stamp_unit
    import vskew_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int TS_W   = 32,
    parameter int LINE_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPORT-1:0]      port_en,
    input  logic                  sync_mode,
    input  logic                  fsync_pulse,
    input  logic [LINE_W-1:0]     line_sel,
    input  logic [NPORT-1:0]      vsync,
    input  logic [NPORT-1:0]      line_begin,
    input  logic [NPORT-1:0]      frz_set,
    input  logic [NPORT-1:0]      frz_clr,
    input  logic [NPORT-1:0]      rd_sof,
    input  logic [NPORT-1:0]      rd_sol,
    output logic [NPORT*TS_W-1:0] sof_stamp,
    output logic [NPORT*TS_W-1:0] sol_stamp,
    output logic [NPORT-1:0]      stamp_valid,
    output logic                  stamp_ready,
    output logic [NPORT-1:0]      multi_sof,
    output logic [NPORT-1:0]      frozen
);
    vsk_mode_e        mode;
    logic             fs_mode, all_valid;
    logic [TS_W-1:0]  now;
    logic [NPORT-1:0] frz_fall;

    assign mode    = vsk_mode_e'(sync_mode);
    assign fs_mode = (mode == VSK_FRAME_SYNC);

    vskew_counter #(.W(TS_W)) u_cnt (.clk(clk), .rst_n(rst_n), .now(now));

    vskew_freeze #(.N(NPORT)) u_frz (
        .clk(clk), .rst_n(rst_n), .frz_set(frz_set), .frz_clr(frz_clr),
        .rd_sof(rd_sof), .rd_sol(rd_sol), .frozen(frozen), .frz_fall(frz_fall)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        vskew_port #(.TS_W(TS_W), .LINE_W(LINE_W)) u_port (
            .clk(clk), .rst_n(rst_n), .en(port_en[p]), .frozen(frozen[p]),
            .frz_fall(frz_fall[p]), .fs_mode(fs_mode), .fsync(fsync_pulse),
            .line_sel(line_sel), .vsync(vsync[p]), .line_begin(line_begin[p]),
            .now(now), .sof_ts(sof_stamp[p*TS_W +: TS_W]),
            .sol_ts(sol_stamp[p*TS_W +: TS_W]), .valid(stamp_valid[p]),
            .multi_sof(multi_sof[p])
        );
    end

    // Every enabled port valid, with at least one port enabled.
    assign all_valid = (|port_en) & (&(stamp_valid | ~port_en));

    // Ready flag: cleared by a falling freeze bit, set per mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                              stamp_ready <= 1'b0;
        else if (|frz_fall)                      stamp_ready <= 1'b0;
        else if (fs_mode ? (fsync_pulse && all_valid) : all_valid)
                                                 stamp_ready <= 1'b1;
    end

    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (($past(frozen) & ~frozen) != '0) |-> !stamp_ready); // R10
    AST_READY_ON_FSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $rose(stamp_ready) && $past(sync_mode) |-> $past(fsync_pulse)); // R9
endmodule

// File: tb/vskew_stamp_unit_test.sv
module vskew_stamp_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0] port_en = '0, vsync = '0, line_begin = '0;
    logic [NP-1:0] frz_set = '0, frz_clr = '0, rd_sof = '0, rd_sol = '0;
    logic sync_mode = 1'b0, fsync_pulse = 1'b0;
    logic [11:0] line_sel = 12'd3;
    logic [NP*32-1:0] sof_stamp, sol_stamp;
    logic [NP-1:0] stamp_valid, multi_sof, frozen;
    logic stamp_ready;

    always #(CLK_PERIOD/2) clk = ~clk;

    vskew_stamp_unit uut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .sync_mode(sync_mode),
        .fsync_pulse(fsync_pulse), .line_sel(line_sel), .vsync(vsync),
        .line_begin(line_begin), .frz_set(frz_set), .frz_clr(frz_clr),
        .rd_sof(rd_sof), .rd_sol(rd_sol), .sof_stamp(sof_stamp),
        .sol_stamp(sol_stamp), .stamp_valid(stamp_valid), .stamp_ready(stamp_ready),
        .multi_sof(multi_sof), .frozen(frozen)
    );

    int checks = 0, failures = 0;
    bit cmp_on = 0, finished = 0;

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    logic [31:0] m_cnt = 0;
    logic [31:0] m_sof [NP], m_sol [NP];
    int          m_lc [NP];
    bit          m_vsq [NP], m_arm [NP], m_val [NP], m_seen [NP], m_mul [NP];
    bit          m_frz [NP], m_gs [NP], m_gl [NP], m_rdy = 0;

    always @(posedge clk) begin
        bit rel, anyf, allv, anyfall, edg, hit;
        bit nf [NP], fall [NP];
        if (!rst_n) begin
            m_cnt = 0; m_rdy = 0;
            for (int p = 0; p < NP; p++) begin
                m_sof[p] = 0; m_sol[p] = 0; m_lc[p] = 0; m_vsq[p] = 0; m_arm[p] = 0;
                m_val[p] = 0; m_seen[p] = 0; m_mul[p] = 0; m_frz[p] = 0; m_gs[p] = 0; m_gl[p] = 0;
            end
        end else begin
            anyf = 0; rel = 1;
            for (int p = 0; p < NP; p++)
                if (m_frz[p]) begin
                    anyf = 1;
                    if (!((m_gs[p] || rd_sof[p]) && (m_gl[p] || rd_sol[p]))) rel = 0;
                end
            rel = rel && anyf;
            anyfall = 0;
            for (int p = 0; p < NP; p++) begin
                nf[p] = frz_set[p] || (m_frz[p] && !rel && !frz_clr[p]);
                fall[p] = m_frz[p] && !nf[p];
                if (fall[p]) anyfall = 1;
                if (frz_set[p]) begin m_gs[p] = 0; m_gl[p] = 0; end
                else if (m_frz[p]) begin m_gs[p] |= rd_sof[p]; m_gl[p] |= rd_sol[p]; end
            end
            allv = (port_en != 0);
            for (int p = 0; p < NP; p++) if (port_en[p] && !m_val[p]) allv = 0;
            if (anyfall) m_rdy = 0;
            else if (sync_mode ? (fsync_pulse && allv) : allv) m_rdy = 1;
            for (int p = 0; p < NP; p++) begin
                edg = port_en[p] && vsync[p] && !m_vsq[p];
                hit = port_en[p] && m_arm[p] && !edg && line_begin[p] && (m_lc[p] + 1 == int'(line_sel));
                if (edg && !m_frz[p]) m_sof[p] = m_cnt;
                if (hit && !m_frz[p]) m_sol[p] = m_cnt;
                if (!port_en[p] || fall[p]) m_val[p] = 0;
                else if (!m_frz[p]) begin
                    if (hit) m_val[p] = 1;
                    else if (edg) m_val[p] = 0;
                    else if (sync_mode && fsync_pulse) m_val[p] = 0;
                end
                if (!port_en[p]) begin m_arm[p] = 0; m_lc[p] = 0; end
                else if (edg) begin m_arm[p] = 1; m_lc[p] = 0; end
                else if (line_begin[p] && m_arm[p]) begin
                    m_lc[p]++;
                    if (hit) m_arm[p] = 0;
                end
                if (!port_en[p] || !sync_mode) begin m_seen[p] = 0; m_mul[p] = 0; end
                else if (fsync_pulse) begin m_seen[p] = edg; m_mul[p] = 0; end
                else if (edg) begin m_mul[p] = m_mul[p] || m_seen[p]; m_seen[p] = 1; end
                m_vsq[p] = vsync[p];
                m_frz[p] = nf[p];
            end
            m_cnt = m_cnt + 1;
        end
    end

    // Compare every output with the model each cycle
    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            for (int p = 0; p < NP; p++) begin
                check(64'(sof_stamp[p*32 +: 32]), 64'(m_sof[p]), $sformatf("R1 R2 sof port%0d", p));
                check(64'(sol_stamp[p*32 +: 32]), 64'(m_sol[p]), $sformatf("R3 sol port%0d", p));
                check(64'(stamp_valid[p]), 64'(m_val[p]), $sformatf("R4 R7 valid port%0d", p));
                check(64'(frozen[p]), 64'(m_frz[p]), $sformatf("R5 R6 frozen port%0d", p));
                check(64'(multi_sof[p]), 64'(m_mul[p]), $sformatf("R11 multi port%0d", p));
            end
            check(64'(stamp_ready), 64'(m_rdy), "R8 R9 R10 ready");
        end
    end

    // Stimulus generator
    int t = 0, fs_per = 0;
    bit dbl2 = 0;
    logic [NP-1:0] q_set = '0, q_clr = '0, q_rs = '0, q_rl = '0;
    int flen [NP] = '{60, 64, 70, 66};
    int offs [NP] = '{0, 17, 33, 8};

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            t++;
            for (int p = 0; p < NP; p++) begin
                int pos = (t + offs[p]) % flen[p];
                vsync[p] = (pos < 3) || (dbl2 && p == 2 && pos >= 40 && pos < 42);
                line_begin[p] = (pos >= 6) && ((pos - 6) % 5 == 0);
            end
            fsync_pulse = (fs_per > 0) && (t % fs_per == 0);
            frz_set = q_set; frz_clr = q_clr; rd_sof = q_rs; rd_sol = q_rl;
            q_set = '0; q_clr = '0; q_rs = '0; q_rl = '0;
        end
    endtask

    task automatic read_all(input logic [NP-1:0] which);
        for (int p = 0; p < NP; p++)
            if (which[p]) begin
                q_rs = NP'(1) << p; cyc(1);
                cyc(2);
                q_rl = NP'(1) << p; cyc(1);
                cyc(3);
            end
    endtask

    initial begin
        cyc(3);
        @(negedge clk);
        // R12: reset state before release
        check(64'(sof_stamp[63:0]) | 64'(sol_stamp[63:0]), 64'd0, "R12 stamps after reset");
        check(64'({stamp_valid, multi_sof, frozen, stamp_ready}), 64'd0, "R12 flags after reset");
        rst_n = 1'b1;
        cmp_on = 1;
        // R2 R3 R8: free-run, all ports enabled
        port_en = 4'hF;
        cyc(400);
        // R5 R6 R10: freeze all, then read every stamp so the freeze releases
        q_set = 4'hF; cyc(1);
        cyc(80);
        read_all(4'hF);
        cyc(150);
        // R6: freeze two ports, read one partly, clear both directly
        q_set = 4'b0110; cyc(1);
        cyc(40);
        q_rs = 4'b0010; cyc(1);
        cyc(20);
        q_clr = 4'b0110; cyc(1);
        cyc(150);
        // R4: port 3 disabled
        port_en = 4'b0111;
        cyc(250);
        port_en = 4'hF;
        // R3: line number 0 never stamps
        line_sel = 12'd0;
        cyc(200);
        line_sel = 12'd7;
        cyc(200);
        line_sel = 12'd3;
        // R9 R11: frame-sync mode with a double frame start on port 2
        sync_mode = 1'b1; fs_per = 80; dbl2 = 1;
        cyc(600);
        q_set = 4'b1011; cyc(1);
        cyc(100);
        read_all(4'b1011);
        cyc(200);
        dbl2 = 0;
        cyc(200);
        // R1 R8: back to free-run
        sync_mode = 1'b0; fs_per = 0;
        cyc(200);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule